// File: doc/BRIEF.md
# Shift-Add Constant-Coefficient FIR Filter

This block is a four-tap direct-form FIR filter whose coefficients are fixed at design time. It uses no multipliers. Each coefficient product is written as a set of arithmetic right shifts of a sample, and these are summed by a chain of adders and subtractors. One signed fractional sample enters per cycle when the input valid is high. A three-deep delay line holds the older samples, and a registered, saturated result leaves one cycle later.

Two taps share bits at the same shift positions, so the sum of the current sample and the sample two steps older is formed once. That sum is reused at four shifts. All internal terms are kept at full precision. The only precision loss is the final scaling back to the sample format. That step rounds toward minus infinity and then clamps to the 16-bit range.

Top module: `fir_sa_top`

## Requirements
- R1: While `rst_ni` is low, `y_o` is 0, `out_valid_o` is 0 and the delay line is all zero. A sample taken right after reset therefore sees zero history.
- R2: `out_valid_o` equals `in_valid_i` delayed by exactly one clock cycle.
- R3: Samples are 16-bit two's complement fractions (value = code / 32768). For a valid sample x[n], with x[n-1..n-3] the three previous valid samples, the output is `y = floor((59*x[n] + 46*x[n-1] - 77*x[n-2] + 38*x[n-3]) / 128)` in code units, clamped to [-32768, 32767].
- R4: A cycle with `in_valid_i` low does not shift the delay line and leaves `y_o` unchanged. The next valid sample uses the same history as if the idle cycle had not occurred.
- R5: A result above 32767 is output as 32767. Example: codes x[n]=32767, x[n-1]=32767, x[n-2]=-32768, x[n-3]=32767.
- R6: A result below -32768 is output as -32768. Example: codes x[n]=-32768, x[n-1]=-32768, x[n-2]=32767, x[n-3]=-32768.
- R7: A single full-scale negative sample (-32768) between zeros gives, on successive valid cycles, -15104, -11776, 19712, -9728 and then 0.
- R8: A single sample of 16384 between zeros gives, on successive valid cycles, 7552, 5888, -9856, 4864 and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample strobe for `x_i` |
| x_i | input | 16 | Input sample, signed fraction |
| out_valid_o | output | 1 | Result strobe, one cycle after `in_valid_i` |
| y_o | output | 16 | Filtered sample, signed fraction, saturated |

## Verification
The checker runs on every cycle. It confirms that the output strobe trails the input strobe by one cycle. On idle cycles it confirms that both the output and the delay line stay frozen, and on valid cycles it confirms that the delay line takes in the presented sample. The arithmetic can only be shown by the bench's scenarios:
- two impulse responses with known values, one of them full-scale negative;
- a long pseudo-random stream with gaps, compared against an integer model of the inner product;
- both saturation directions;
- a reset in the middle of a stream, which must leave no trace of earlier samples.

// File: rtl/fir_sa_pkg.sv
`timescale 1ns/1ps
package fir_sa_pkg;
  localparam int DATA_W  = 16;
  localparam int FRAC_W  = 7;                  // coefficient fraction bits
  localparam int SUM_W   = DATA_W + 1;         // shared subexpression width
  localparam int ACC_W   = DATA_W + FRAC_W + 2;
  localparam int DEPTH   = 3;                  // delay line taps
  localparam int N_TERMS = 13;

  localparam int SRC_SHARED = 0;
  localparam int SRC_X0     = 1;
  localparam int SRC_X1     = 2;
  localparam int SRC_X2     = 3;
  localparam int SRC_X3     = 4;

  // shift-add decomposition of the fixed coefficient set
  localparam int TERM_SRC [N_TERMS] = '{
    SRC_SHARED, SRC_SHARED, SRC_SHARED, SRC_SHARED,
    SRC_X0, SRC_X2,
    SRC_X1, SRC_X1, SRC_X1, SRC_X1,
    SRC_X3, SRC_X3, SRC_X3};
  localparam int TERM_SHIFT [N_TERMS] = '{
    2, 3, 6, 7,
    4, 0,
    2, 4, 5, 6,
    2, 5, 6};
  localparam bit TERM_NEG [N_TERMS] = '{
    1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0};
endpackage

// File: rtl/fir_sa_addsub.sv
`timescale 1ns/1ps
module fir_sa_addsub #(
  parameter int W   = 8,
  parameter bit SUB = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  // subtract = add inverted operand with carry-in one
  logic [W-1:0] b_eff;
  assign b_eff = SUB ? ~b_i : b_i;
  assign s_o   = a_i + b_eff + W'(SUB);
endmodule

// File: rtl/fir_sa_delay.sv
`timescale 1ns/1ps
module fir_sa_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [W-1:0]              d_i,
  output logic [DEPTH-1:0][W-1:0]   tap_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] nxt;
    if (i == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = tap_o[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   tap_o[i] <= '0;
      else if (en_i) tap_o[i] <= nxt;
    end
  end
endmodule

// File: rtl/fir_sa_tree.sv
`timescale 1ns/1ps
module fir_sa_tree
  import fir_sa_pkg::*;
(
  input  logic [DATA_W-1:0] x0_i,
  input  logic [DATA_W-1:0] x1_i,
  input  logic [DATA_W-1:0] x2_i,
  input  logic [DATA_W-1:0] x3_i,
  output logic [ACC_W-1:0]  acc_o
);
  // shared subexpression x[n] + x[n-2]
  logic [SUM_W-1:0] shared;
  fir_sa_addsub #(.W(SUM_W), .SUB(1'b0)) u_shared (
    .a_i ({x0_i[DATA_W-1], x0_i}),
    .b_i ({x2_i[DATA_W-1], x2_i}),
    .s_o (shared)
  );

  logic [ACC_W-1:0] sx0, sx1, sx2, sx3, ssh;
  assign sx0 = ACC_W'(signed'(x0_i));
  assign sx1 = ACC_W'(signed'(x1_i));
  assign sx2 = ACC_W'(signed'(x2_i));
  assign sx3 = ACC_W'(signed'(x3_i));
  assign ssh = ACC_W'(signed'(shared));

  logic [N_TERMS:0][ACC_W-1:0] part;
  assign part[0] = '0;

  for (genvar i = 0; i < N_TERMS; i++) begin : g_term
    logic [ACC_W-1:0] src;
    logic [ACC_W-1:0] term;
    if (TERM_SRC[i] == SRC_SHARED) begin : g_sh
      assign src = ssh;
    end else if (TERM_SRC[i] == SRC_X0) begin : g_x0
      assign src = sx0;
    end else if (TERM_SRC[i] == SRC_X1) begin : g_x1
      assign src = sx1;
    end else if (TERM_SRC[i] == SRC_X2) begin : g_x2
      assign src = sx2;
    end else begin : g_x3
      assign src = sx3;
    end
    // x >> k at full precision, aligned to 2^-FRAC_W scale
    assign term = src << (FRAC_W - TERM_SHIFT[i]);
    fir_sa_addsub #(.W(ACC_W), .SUB(TERM_NEG[i])) u_acc (
      .a_i (part[i]),
      .b_i (term),
      .s_o (part[i+1])
    );
  end

  assign acc_o = part[N_TERMS];
endmodule

// File: rtl/fir_sa_sat.sv
`timescale 1ns/1ps
module fir_sa_sat
  import fir_sa_pkg::*;
(
  input  logic [ACC_W-1:0]  acc_i,
  output logic [DATA_W-1:0] y_o
);
  localparam logic signed [ACC_W-1:0] POS_MAX = ACC_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_MIN = -ACC_W'(2 ** (DATA_W - 1));

  logic signed [ACC_W-1:0] scaled;
  assign scaled = signed'(acc_i) >>> FRAC_W;  // floor

  always_comb begin
    if (scaled > POS_MAX)      y_o = POS_MAX[DATA_W-1:0];
    else if (scaled < NEG_MIN) y_o = NEG_MIN[DATA_W-1:0];
    else                       y_o = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/fir_sa_top.sv
`timescale 1ns/1ps
module fir_sa_top
  import fir_sa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] y_o
);
  logic [DEPTH-1:0][DATA_W-1:0] dly;
  logic [ACC_W-1:0]             acc;
  logic [DATA_W-1:0]            y_sat;

  fir_sa_delay #(.W(DATA_W), .DEPTH(DEPTH)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_valid_i),
    .d_i    (x_i),
    .tap_o  (dly)
  );

  fir_sa_tree u_tree (
    .x0_i  (x_i),
    .x1_i  (dly[0]),
    .x2_i  (dly[1]),
    .x3_i  (dly[2]),
    .acc_o (acc)
  );

  fir_sa_sat u_sat (
    .acc_i (acc),
    .y_o   (y_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y_o         <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) y_o <= y_sat;
    end
  end
endmodule

// File: rtl/fir_sa_checker.sv
`timescale 1ns/1ps
module fir_sa_checker
  import fir_sa_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           in_valid_i,
  input logic [DATA_W-1:0]              x_i,
  input logic                           out_valid_o,
  input logic [DATA_W-1:0]              y_o,
  input logic [DEPTH-1:0][DATA_W-1:0]   dly_i
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r4_output_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(y_o));

  a_r4_history_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(dly_i));

  a_r3_history_takes_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (dly_i[0] == $past(x_i)));
endmodule

bind fir_sa_top fir_sa_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .x_i         (x_i),
  .out_valid_o (out_valid_o),
  .y_o         (y_o),
  .dly_i       (dly)
);

// File: tb/fir_sa_top_test.sv
`timescale 1ns/1ps
module fir_sa_top_test;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] x_in = '0;
  logic               out_valid;
  logic [15:0]        y_out;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  hist [3];
  int  exp_y  = 0;

  always #2 clk = ~clk;

  fir_sa_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .x_i         (x_in),
    .out_valid_o (out_valid),
    .y_o         (y_out)
  );

  function automatic int model(int a0, int a1, int a2, int a3);
    longint acc;
    longint q;
    acc = 59 * longint'(a0) + 46 * longint'(a1) - 77 * longint'(a2) + 38 * longint'(a3);
    q   = acc >>> 7;
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic send(input bit v, input int x, input string tag);
    in_valid = v;
    x_in     = 16'(x);
    if (v) begin
      exp_y   = model(x, hist[0], hist[1], hist[2]);
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = x;
    end
    @(negedge clk);
    chk(tag, "valid", int'(out_valid), int'(v));
    chk(tag, "y", int'($signed(y_out)), exp_y);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "reset valid", int'(out_valid), 0);
    chk("R1", "reset y", int'($signed(y_out)), 0);
    rst_ni = 1'b1;
    hist = '{0, 0, 0};
    exp_y = 0;
    @(negedge clk);
  endtask

  task automatic t_impulse_pos();
    int lit [5] = '{7552, 5888, -9856, 4864, 0};
    for (int i = 0; i < 5; i++) begin
      send(1'b1, (i == 0) ? 16384 : 0, "R8");
      chk("R8", "impulse tap", int'($signed(y_out)), lit[i]);
    end
  endtask

  task automatic t_impulse_neg();
    int lit [5] = '{-15104, -11776, 19712, -9728, 0};
    for (int i = 0; i < 5; i++) begin
      send(1'b1, (i == 0) ? -32768 : 0, "R7");
      chk("R7", "full-scale tap", int'($signed(y_out)), lit[i]);
    end
  endtask

  task automatic t_gaps();
    send(1'b1, 16384, "R4");
    send(1'b0, 0, "R4");
    chk("R4", "idle hold", int'($signed(y_out)), 7552);
    send(1'b0, -1234, "R2");
    send(1'b1, 0, "R4");
    chk("R4", "history kept", int'($signed(y_out)), 5888);
    send(1'b0, 777, "R4");
    send(1'b1, 0, "R4");
    chk("R4", "history kept 2", int'($signed(y_out)), -9856);
    send(1'b1, 0, "R2");
  endtask

  task automatic t_sat_pos();
    send(1'b1, 32767, "R5");
    send(1'b1, -32768, "R5");
    send(1'b1, 32767, "R5");
    send(1'b1, 32767, "R5");
    chk("R5", "clamp high", int'($signed(y_out)), 32767);
  endtask

  task automatic t_sat_neg();
    send(1'b1, -32768, "R6");
    send(1'b1, 32767, "R6");
    send(1'b1, -32768, "R6");
    send(1'b1, -32768, "R6");
    chk("R6", "clamp low", int'($signed(y_out)), -32768);
  endtask

  task automatic t_stream();
    logic [31:0] lfsr = 32'h1ace_b00c;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[3:0] != 4'h0, int'($signed(lfsr[27:12])), "R3");
    end
  endtask

  task automatic t_mid_reset();
    send(1'b1, 20000, "R3");
    send(1'b1, -30000, "R3");
    send(1'b1, 12345, "R3");
    do_reset();
    send(1'b1, 16384, "R1");
    chk("R1", "zero history tap0", int'($signed(y_out)), 7552);
    send(1'b1, 0, "R1");
    chk("R1", "zero history tap1", int'($signed(y_out)), 5888);
  endtask

  initial begin
    hist = '{0, 0, 0};
    @(negedge clk);
    do_reset();
    t_impulse_pos();
    t_impulse_neg();
    t_gaps();
    t_sat_pos();
    t_sat_neg();
    t_stream();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule